// File: doc/BRIEF.md
# Protected Flash Command Sequencer

This block sits between a host write bus and the model of a flash array. It watches every write event (address plus data byte) and recognises four unlock-protected command sequences: byte program, sector erase, block erase and chip erase. Each sequence must arrive exactly, one write after another. Any write that does not fit the next expected step drops the sequencer back to idle, and that write does not open a new sequence.

When a sequence completes, the block emits a one-cycle start pulse. It also presents the operation kind, the target address and the data byte to the storage model and the status logic. It then holds `busy` for a fixed number of clock cycles that depends on the kind. While `busy` is high every write is discarded. A sequence that was half entered during that time does not resume afterwards.

The durations are given in microseconds and are scaled by the clock frequency in MHz, so the default program time of 20 us becomes a cycle count.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `busy` and `op_go` are 0, and `op_kind`, `op_addr` and `op_data` are all zero.
- R2: The four writes AAh to 5555h, 55h to 2AAAh, A0h to 5555h and then data D to address A start a program. In the cycle after the last write, `op_go` is 1 for exactly one cycle, with `op_kind`=0, `op_addr`=A and `op_data`=D.
- R3: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and then 30h to address A start a sector erase. The outputs are `op_kind`=1, `op_addr`=A with bits 11..0 cleared, and `op_data`=FFh.
- R4: The same five-write prefix followed by 50h to address A starts a block erase. The outputs are `op_kind`=2, `op_addr`=A with bits 15..0 cleared, and `op_data`=FFh.
- R5: The same prefix followed by 10h to 5555h starts a chip erase, with `op_kind`=3, `op_addr`=0 and `op_data`=FFh. If 10h is written to any other address, nothing starts.
- R6: `busy` rises together with `op_go`. It stays high for exactly PROG_US, SECT_US, BLOCK_US or CHIP_US times CLK_MHZ cycles, according to the kind.
- R7: A write made while `busy` is high has no effect. It causes no `op_go`, does not alter the outputs, and does not advance a sequence.
- R8: A write that does not match the expected next step returns the sequencer to idle. Any later operation then needs the complete sequence from the first step.
- R9: A sixth write whose data is not 30h, 50h or 10h starts nothing.
- R10: From `op_go` until `busy` falls, `op_kind`, `op_addr` and `op_data` stay constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One write event in this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| op_go | output | 1 | One-cycle pulse when an operation starts |
| op_kind | output | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| op_addr | output | ADDR_W | Target address, aligned for erases |
| op_data | output | 8 | Program byte, or FFh for erases |
| busy | output | 1 | Internal operation in progress |

## Verification
The bench builds the block with CLK_MHZ=1 and with durations of 4, 7, 11 and 15 cycles. These short, distinct values let the busy window of every kind be measured to the exact cycle. The program window is short enough that a run of writes issued right after a start falls partly inside the busy window and partly after it. This shows that writes during `busy` are dropped and that the leftover steps of a sequence are rejected. The default 19-bit address width is kept, so the sector and block alignment is checked on addresses whose bits lie above bit 16.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W   = 19,
  parameter int CLK_MHZ  = 33,
  parameter int PROG_US  = 20,
  parameter int SECT_US  = 25000,
  parameter int BLOCK_US = 25000,
  parameter int CHIP_US  = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              op_go,
  output logic [1:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic              busy
);
  localparam int PROG_CYC  = PROG_US * CLK_MHZ;
  localparam int SECT_CYC  = SECT_US * CLK_MHZ;
  localparam int BLOCK_CYC = BLOCK_US * CLK_MHZ;
  localparam int CHIP_CYC  = CHIP_US * CLK_MHZ;
  localparam int MAX_PS    = PROG_CYC > SECT_CYC ? PROG_CYC : SECT_CYC;
  localparam int MAX_BC    = BLOCK_CYC > CHIP_CYC ? BLOCK_CYC : CHIP_CYC;
  localparam int MAX_CYC   = MAX_PS > MAX_BC ? MAX_PS : MAX_BC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  localparam logic [1:0] K_PROG = 2'd0, K_SECT = 2'd1, K_BLOCK = 2'd2, K_CHIP = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PDATA, S_E1, S_E2, S_ECODE} step_t;

  step_t             step, nxt;
  logic [CNT_W-1:0]  cnt, dur;
  logic              start;
  logic [1:0]        kind;
  logic [ADDR_W-1:0] tgt;

  wire hit_5555 = wr_addr == ADDR_W'(16'h5555);
  wire hit_2aaa = wr_addr == ADDR_W'(16'h2AAA);
  wire first_ok = hit_5555 && wr_data == 8'hAA;
  wire second_ok = hit_2aaa && wr_data == 8'h55;
  wire accept = wr_en && !busy;

  assign busy = cnt != '0;

  always_comb begin
    nxt   = S_IDLE;
    start = 1'b0;
    kind  = K_PROG;
    tgt   = wr_addr;
    unique case (step)
      S_IDLE:  if (first_ok) nxt = S_U1;
      S_U1:    if (second_ok) nxt = S_U2;
      S_U2: begin
        if (hit_5555 && wr_data == 8'hA0) nxt = S_PDATA;
        else if (hit_5555 && wr_data == 8'h80) nxt = S_E1;
      end
      S_PDATA: start = 1'b1;
      S_E1:    if (first_ok) nxt = S_E2;
      S_E2:    if (second_ok) nxt = S_ECODE;
      S_ECODE: begin
        if (wr_data == 8'h30) begin
          start = 1'b1;
          kind  = K_SECT;
          tgt   = wr_addr & ~ADDR_W'(16'h0FFF);
        end else if (wr_data == 8'h50) begin
          start = 1'b1;
          kind  = K_BLOCK;
          tgt   = wr_addr & ~ADDR_W'(17'h0FFFF);
        end else if (wr_data == 8'h10 && hit_5555) begin
          start = 1'b1;
          kind  = K_CHIP;
          tgt   = '0;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (kind)
      K_PROG:  dur = CNT_W'(PROG_CYC);
      K_SECT:  dur = CNT_W'(SECT_CYC);
      K_BLOCK: dur = CNT_W'(BLOCK_CYC);
      default: dur = CNT_W'(CHIP_CYC);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step    <= S_IDLE;
      cnt     <= '0;
      op_go   <= 1'b0;
      op_kind <= K_PROG;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      op_go <= 1'b0;
      if (accept) step <= nxt;
      if (accept && start) begin
        op_go   <= 1'b1;
        op_kind <= kind;
        op_addr <= tgt;
        op_data <= (kind == K_PROG) ? wr_data : 8'hFF;
        cnt     <= dur;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

module flash_cmd_seq_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              op_go,
  input logic [1:0]        op_kind,
  input logic [ADDR_W-1:0] op_addr,
  input logic [7:0]        op_data,
  input logic              busy
);
  AST_GO_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n) op_go |-> busy); // R6
  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n) op_go |=> !op_go); // R2
  AST_SECTOR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go && op_kind == 2'd1) |-> (op_addr[11:0] == 12'h000 && op_data == 8'hFF)); // R3
  AST_BLOCK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go && op_kind == 2'd2) |-> (op_addr[15:0] == 16'h0000 && op_data == 8'hFF)); // R4
  AST_CHIP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go && op_kind == 2'd3) |-> (op_addr == '0 && op_data == 8'hFF)); // R5
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && busy) |=> !op_go); // R7
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_go) |-> ($stable(op_kind) && $stable(op_addr) && $stable(op_data))); // R10
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op_go(op_go), .op_kind(op_kind),
  .op_addr(op_addr), .op_data(op_data), .busy(busy)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
  localparam int AW = 19;
  localparam int DP = 4, DS = 7, DB = 11, DC = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          op_go, busy;
  logic [1:0]    op_kind;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data;

  flash_cmd_seq #(.ADDR_W(AW), .CLK_MHZ(1), .PROG_US(DP), .SECT_US(DS),
                  .BLOCK_US(DB), .CHIP_US(DC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_go(op_go), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data), .busy(busy));

  always #2 clk = ~clk;

  typedef struct { logic [1:0] kind; logic [AW-1:0] addr; logic [7:0] data; int dur; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic unlock;
    wr(19'h5555, 8'hAA); wr(19'h2AAA, 8'h55);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    unlock; wr(19'h5555, 8'hA0); wr(a, d);
  endtask

  task automatic erase(input logic [AW-1:0] a, input logic [7:0] code);
    unlock; wr(19'h5555, 8'h80); unlock; wr(a, code);
  endtask

  task automatic expect_op(input logic [1:0] k, input logic [AW-1:0] a, input logic [7:0] d, input int dur);
    exp_t e; e.kind = k; e.addr = a; e.data = d; e.dur = dur; q.push_back(e);
  endtask

  task automatic settle;
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  exp_t cur;
  bit   tracking = 0, prev_go = 0, hold_ok = 1;
  int   bcnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_go && op_go) chk(0, "R2", "op_go wider than one cycle", 1, 0);
      if (tracking && !op_go) begin
        if (busy) begin
          bcnt++;
          if (op_kind != cur.kind || op_addr != cur.addr || op_data != cur.data) hold_ok = 0;
        end else begin
          chk(bcnt == cur.dur, "R6", "busy length", bcnt, cur.dur);
          chk(hold_ok, "R10", "fields held while busy", hold_ok, 1);
          tracking = 0;
        end
      end
      if (op_go) begin
        if (q.size() == 0) chk(0, "R7/R8", "unexpected op_go", op_addr, 0);
        else begin
          cur = q.pop_front();
          chk(op_kind == cur.kind, "R2-5 kind", "op_kind", op_kind, cur.kind);
          chk(op_addr == cur.addr, "R2-5 addr", "op_addr", op_addr, cur.addr);
          chk(op_data == cur.data, "R2-5 data", "op_data", op_data, cur.data);
          chk(busy, "R6", "busy with op_go", busy, 1);
          tracking = 1; bcnt = 1; hold_ok = 1;
        end
      end
      prev_go = op_go;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      chk(0, "watchdog", "run timed out", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !op_go, "R1", "busy/op_go after reset", {busy, op_go}, 0);
    chk(op_kind == 0 && op_addr == 0 && op_data == 0, "R1", "fields after reset", op_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    expect_op(2'd0, 19'h12345, 8'h3C, DP); prog(19'h12345, 8'h3C); settle;     // R2
    expect_op(2'd1, 19'h45000, 8'hFF, DS); erase(19'h45678, 8'h30); settle;    // R3
    expect_op(2'd2, 19'h70000, 8'hFF, DB); erase(19'h7ABCD, 8'h50); settle;    // R4
    expect_op(2'd3, 19'h00000, 8'hFF, DC); erase(19'h5555, 8'h10); settle;     // R5
    erase(19'h5554, 8'h10); settle;                                            // R5 wrong address
    erase(19'h45678, 8'h20); settle;                                           // R9
    // R8: break at step 3, then tail of a sequence must not complete
    unlock; wr(19'h5555, 8'hAA); wr(19'h2AAA, 8'h55); wr(19'h5555, 8'hA0); wr(19'h00010, 8'h77); settle;
    // R8: wrong data in step 2, then a clean program still works
    wr(19'h5555, 8'hAA); wr(19'h2AAA, 8'h54);
    expect_op(2'd0, 19'h00ABC, 8'h5A, DP); prog(19'h00ABC, 8'h5A); settle;
    // R7: full program sequence issued right behind a start
    expect_op(2'd0, 19'h7FFFF, 8'h01, DP); prog(19'h7FFFF, 8'h01);
    prog(19'h00123, 8'h99); settle;
    // R7: long erase, writes land inside busy
    expect_op(2'd1, 19'h23000, 8'hFF, DS); erase(19'h23FFF, 8'h30);
    unlock; settle;
    expect_op(2'd0, 19'h00042, 8'hC3, DP); prog(19'h00042, 8'hC3); settle;   // R7 idle afterwards

    chk(q.size() == 0, "R2-R9", "expected operations left", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule